// File: doc/BRIEF.md
# Read Data Parity Error Reporter

This block sits on one bus side of a PCI bridge and watches the read data phases for which the bridge is the initiator. On every completed data phase it checks even parity over the 32-bit address/data bus, the four command/byte-enable lines and the parity line. The parity line arrives one clock after its data. A mismatch produces a one-clock active-low error strobe, gated by a response-enable input. It also sets sticky status bits that software clears with write-one-to-clear pulses.

Every data word, good or bad, is pushed into a forwarding buffer with its received parity bit untouched and a poison flag. The requester on the other bus receives exactly what the target sent. A parity error never stops the transfer. Words still in the buffer can be dropped with a flush pulse, and their poison flags go with them, so prefetched bad data that nobody reads never reaches the other bus.

Top module: `rd_par_reporter`

## Requirements
- R1: A data phase is in error when the number of ones across `ad[31:0]`, `cbe_n[3:0]` and the `par` value sampled on the clock edge after that data phase is odd.
- R2: A data phase is an edge on which `rd_phase` is 1 and both `irdy_n` and `trdy_n` are 0. On any other edge the bus is neither checked nor forwarded.
- R3: For an erroneous data phase at edge k with `per_en` at 1, `perr_n` is 0 for exactly the one clock following edge k+2. With `per_en` at 0, `perr_n` stays 1.
- R4: Errors on consecutive data phases give `perr_n` low on consecutive clocks, one clock per error, each at the same two-edge delay.
- R5: `sts_dpe` becomes 1 after edge k+2 for any erroneous data phase, whatever `per_en` is.
- R6: `sts_dpd` becomes 1 after edge k+2 for an erroneous data phase only when `per_en` is 1.
- R7: Both status bits hold their value until a 1 on `clr_dpe` / `clr_dpd` clears the matching bit. If a new error sets a bit on the edge where its clear is applied, the bit stays 1.
- R8: Each data phase is written into the forwarding buffer in bus order, and becomes visible after edge k+2. The entry carries the phase's `ad` value in `fwd_data`, the received `par` in `fwd_par` (not regenerated) and `fwd_poison` equal to 1 exactly when the phase was in error. `fwd_rd` at 1 with `fwd_valid` at 1 pops the head.
- R9: An erroneous data phase does not drop, stall or end the transfer: the phases after it are checked and forwarded like any other.
- R10: A 1 on `fwd_flush` discards every buffered entry and its poison flag, so `fwd_valid` is 0 on the next clock. A flush overrides a same-edge write or pop.
- R11: After reset `perr_n` is 1, both status bits are 0 and `fwd_valid` and `fwd_full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_phase | input | 1 | A read with this side as initiator is in progress |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| ad | input | 32 | Address/data bus |
| cbe_n | input | 4 | Command/byte enables, active low |
| par | input | 1 | Even parity for the previous clock's `ad` and `cbe_n` |
| per_en | input | 1 | Parity error response enable |
| clr_dpe | input | 1 | Write-one-to-clear pulse for `sts_dpe` |
| clr_dpd | input | 1 | Write-one-to-clear pulse for `sts_dpd` |
| perr_n | output | 1 | Data parity error strobe, active low |
| sts_dpe | output | 1 | Sticky detected-parity-error status |
| sts_dpd | output | 1 | Sticky data-parity-detected status |
| fwd_rd | input | 1 | Pop the buffer head |
| fwd_flush | input | 1 | Discard all buffered entries |
| fwd_valid | output | 1 | Buffer head is valid |
| fwd_full | output | 1 | Buffer cannot accept another word |
| fwd_data | output | 32 | Head data word |
| fwd_par | output | 1 | Head parity bit as received |
| fwd_poison | output | 1 | Head word had a parity error |

## Verification
The bench checks the strobe on every clock, so a pulse one edge early or late, two clocks long, or merged across back-to-back errors shows up as a mismatch. Running with the enable low separates the two status bits: a design that gated the detected bit, or left the reported bit ungated, sets the wrong one. It drives bad parity on edges where only one ready line is low, or where the read qualifier is off, to catch a checker that looks at the wrong edges. The byte enables vary from word to word, so leaving them out of the parity sum flags good words. A clear applied on the same edge as a new error, and a flush followed by a clean word, catch a clear that takes priority over a new error and poison that outlives its word.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  localparam int AD_W = 32;
  localparam int BE_W = 4;

  typedef struct packed {
    logic            poison;
    logic            par;
    logic [AD_W-1:0] data;
  } fwd_word_t;

  localparam int FWD_W = $bits(fwd_word_t);
endpackage

// File: rtl/rpr_par_check.sv
module rpr_par_check
  import rpr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_phase,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe_n,
  input  logic            par,
  output logic            push,
  output fwd_word_t       push_word,
  output logic            err
);
  // stage 1: capture the data phase
  logic            ph_v;
  logic [AD_W-1:0] ad_q;
  logic [BE_W-1:0] cbe_q;
  logic            dphase;
  // stage 2: parity result, one edge after the data phase
  logic            chk_v;
  fwd_word_t       word_q;
  logic            odd;

  assign dphase = rd_phase & ~irdy_n & ~trdy_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_v <= 1'b0;
    end else begin
      ph_v <= dphase;
    end
    ad_q  <= ad;
    cbe_q <= cbe_n;
  end

  assign odd = ^{ad_q, cbe_q, par};

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_v  <= 1'b0;
      word_q <= '0;
    end else begin
      chk_v <= ph_v;
      if (ph_v) begin
        word_q.data   <= ad_q;
        word_q.par    <= par;
        word_q.poison <= odd;
      end
    end
  end

  assign push      = chk_v;
  assign push_word = word_q;
  assign err       = chk_v & word_q.poison;
endmodule

// File: rtl/rpr_perr_gen.sv
module rpr_perr_gen (
  input  logic clk,
  input  logic rst,
  input  logic err,
  input  logic per_en,
  output logic perr_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      perr_n <= 1'b1;
    end else begin
      perr_n <= ~(err & per_en);
    end
  end
endmodule

// File: rtl/rpr_status.sv
module rpr_status #(
  parameter int NBITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] set,
  input  logic [NBITS-1:0] clr,
  output logic [NBITS-1:0] sts
);
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        sts[i] <= 1'b0;
      end else if (set[i]) begin
        sts[i] <= 1'b1;
      end else if (clr[i]) begin
        sts[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rpr_fwd_fifo.sv
module rpr_fwd_fifo
  import rpr_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      push,
  input  fwd_word_t push_word,
  input  logic      pop,
  input  logic      flush,
  output logic      valid,
  output logic      full,
  output fwd_word_t head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  fwd_word_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok;
  logic          pop_ok;

  assign push_ok = push & (count != DEPTH_C) & ~flush;
  assign pop_ok  = pop & (count != '0) & ~flush;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    nxt = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr] <= push_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign valid = (count != '0);
  assign full  = (count == DEPTH_C);
  assign head  = valid ? mem[rd_ptr] : '0;
endmodule

// File: rtl/rd_par_reporter.sv
module rd_par_reporter
  import rpr_pkg::*;
#(
  parameter int FWD_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_phase,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe_n,
  input  logic            par,
  input  logic            per_en,
  input  logic            clr_dpe,
  input  logic            clr_dpd,
  output logic            perr_n,
  output logic            sts_dpe,
  output logic            sts_dpd,
  input  logic            fwd_rd,
  input  logic            fwd_flush,
  output logic            fwd_valid,
  output logic            fwd_full,
  output logic [AD_W-1:0] fwd_data,
  output logic            fwd_par,
  output logic            fwd_poison
);
  logic      push;
  fwd_word_t push_word;
  logic      err;
  fwd_word_t head;
  logic [1:0] sts_vec;

  rpr_par_check u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_phase  (rd_phase),
    .irdy_n    (irdy_n),
    .trdy_n    (trdy_n),
    .ad        (ad),
    .cbe_n     (cbe_n),
    .par       (par),
    .push      (push),
    .push_word (push_word),
    .err       (err)
  );

  rpr_perr_gen u_perr (
    .clk    (clk),
    .rst    (rst),
    .err    (err),
    .per_en (per_en),
    .perr_n (perr_n)
  );

  // bit 0: detected (ungated), bit 1: reported (gated by enable)
  rpr_status #(.NBITS(2)) u_sts (
    .clk (clk),
    .rst (rst),
    .set ({err & per_en, err}),
    .clr ({clr_dpd, clr_dpe}),
    .sts (sts_vec)
  );

  assign sts_dpe = sts_vec[0];
  assign sts_dpd = sts_vec[1];

  rpr_fwd_fifo #(.DEPTH(FWD_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_word (push_word),
    .pop       (fwd_rd),
    .flush     (fwd_flush),
    .valid     (fwd_valid),
    .full      (fwd_full),
    .head      (head)
  );

  assign fwd_data   = head.data;
  assign fwd_par    = head.par;
  assign fwd_poison = head.poison;
endmodule

// File: rtl/rpr_chk.sv
module rpr_chk (
  input logic clk,
  input logic rst,
  input logic rd_phase,
  input logic irdy_n,
  input logic trdy_n,
  input logic per_en,
  input logic clr_dpe,
  input logic perr_n,
  input logic sts_dpe,
  input logic sts_dpd,
  input logic fwd_flush,
  input logic fwd_valid,
  input logic fwd_full
);
  // R3
  perr_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !perr_n |-> $past(per_en));

  // R2
  perr_needs_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !perr_n |-> $past(rd_phase && !irdy_n && !trdy_n, 3));

  // R5
  perr_sets_dpe_chk: assert property (@(posedge clk) disable iff (rst)
    !perr_n |-> sts_dpe);

  // R6
  dpd_gated_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_dpd) |-> $past(per_en));

  // R7
  dpe_clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sts_dpe) && !$past(rst)) |-> $past(clr_dpe));

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_flush |=> !fwd_valid);

  // R8
  full_is_valid_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_full |-> fwd_valid);
endmodule

bind rd_par_reporter rpr_chk u_rpr_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_phase  (rd_phase),
  .irdy_n    (irdy_n),
  .trdy_n    (trdy_n),
  .per_en    (per_en),
  .clr_dpe   (clr_dpe),
  .perr_n    (perr_n),
  .sts_dpe   (sts_dpe),
  .sts_dpd   (sts_dpd),
  .fwd_flush (fwd_flush),
  .fwd_valid (fwd_valid),
  .fwd_full  (fwd_full)
);

// File: tb/rd_par_reporter_tb_top.sv
`timescale 1ns/1ps
module rd_par_reporter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_phase = 1'b0, irdy_n = 1'b1, trdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = '0;
  logic        par = 1'b0, per_en = 1'b0, clr_dpe = 1'b0, clr_dpd = 1'b0;
  logic        fwd_rd = 1'b0, fwd_flush = 1'b0;
  logic        perr_n, sts_dpe, sts_dpd, fwd_valid, fwd_full, fwd_par, fwd_poison;
  logic [31:0] fwd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rd_par_reporter dut_i (
    .clk(clk), .rst(rst), .rd_phase(rd_phase), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .ad(ad), .cbe_n(cbe_n), .par(par), .per_en(per_en), .clr_dpe(clr_dpe),
    .clr_dpd(clr_dpd), .perr_n(perr_n), .sts_dpe(sts_dpe), .sts_dpd(sts_dpd),
    .fwd_rd(fwd_rd), .fwd_flush(fwd_flush), .fwd_valid(fwd_valid),
    .fwd_full(fwd_full), .fwd_data(fwd_data), .fwd_par(fwd_par),
    .fwd_poison(fwd_poison)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int i);
    return 32'h1234_5678 ^ (i * 32'h0101_0F03);
  endfunction
  function automatic logic [3:0] cbe_of(input int i);
    return 4'(i * 5);
  endfunction
  function automatic logic good_par(input int i);
    return ^{word_of(i), cbe_of(i)};
  endfunction

  task automatic idle_bus();
    rd_phase = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1; ad = '0; cbe_n = '0;
  endtask

  // Streams n back-to-back data phases; checks perr_n every clock (R1, R3, R4)
  task automatic run_stream(input int n, input int base, input logic [7:0] errm,
                            input logic pen, input string req);
    per_en = pen;
    for (int j = 0; j <= n + 3; j++) begin
      @(negedge clk);
      if (j >= 3) begin
        logic exp_n;
        exp_n = !((j - 3) < n && errm[j-3] && pen);
        check(perr_n == exp_n, req, $sformatf("perr_n after edge %0d", j - 1),
              32'(perr_n), 32'(exp_n));
      end
      if (j < n) begin
        rd_phase = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0;
        ad = word_of(base + j); cbe_n = cbe_of(base + j);
      end else begin
        idle_bus();
      end
      if (j >= 1 && j - 1 < n) par = good_par(base + j - 1) ^ errm[j-1];
      else par = 1'b0;
    end
  endtask

  // Pops n entries, checking data, received parity and poison (R8, R9)
  task automatic drain(input int n, input int base, input logic [7:0] errm,
                       input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fwd_rd = 1'b0;
      check(fwd_valid == 1'b1, req, "fwd_valid", 32'(fwd_valid), 32'd1);
      check(fwd_data == word_of(base + i), req, "fwd_data", fwd_data, word_of(base + i));
      check(fwd_par == (good_par(base + i) ^ errm[i]), req, "fwd_par",
            32'(fwd_par), 32'(good_par(base + i) ^ errm[i]));
      check(fwd_poison == errm[i], req, "fwd_poison", 32'(fwd_poison), 32'(errm[i]));
      fwd_rd = 1'b1;
    end
    @(negedge clk);
    fwd_rd = 1'b0;
    check(fwd_valid == 1'b0, req, "empty after drain", 32'(fwd_valid), 32'd0);
  endtask

  task automatic check_sts(input logic e_dpe, input logic e_dpd, input string req);
    check(sts_dpe == e_dpe, req, "sts_dpe", 32'(sts_dpe), 32'(e_dpe));
    check(sts_dpd == e_dpd, req, "sts_dpd", 32'(sts_dpd), 32'(e_dpd));
  endtask

  task automatic clear_all();
    @(negedge clk); clr_dpe = 1'b1; clr_dpd = 1'b1;
    @(negedge clk); clr_dpe = 1'b0; clr_dpd = 1'b0;
    check_sts(1'b0, 1'b0, "R7 clear");
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(perr_n == 1'b1, "R11", "perr_n", 32'(perr_n), 32'd1);
    check_sts(1'b0, 1'b0, "R11");
    check(fwd_valid == 1'b0, "R11", "fwd_valid", 32'(fwd_valid), 32'd0);
    check(fwd_full == 1'b0, "R11", "fwd_full", 32'(fwd_full), 32'd0);
  endtask

  task automatic t_clean();
    run_stream(4, 0, 8'b0000, 1'b1, "R1 clean");
    check_sts(1'b0, 1'b0, "R1 clean");
    drain(4, 0, 8'b0000, "R8 clean");
  endtask

  task automatic t_single_err();
    run_stream(5, 10, 8'b00100, 1'b1, "R3 single");
    repeat (3) @(negedge clk);
    check_sts(1'b1, 1'b1, "R5 R6 R7 sticky");
    drain(5, 10, 8'b00100, "R9 R8 poisoned");
    clear_all();
  endtask

  task automatic t_err_disabled();
    run_stream(3, 30, 8'b010, 1'b0, "R3 disabled");
    check_sts(1'b1, 1'b0, "R5 R6 disabled");
    drain(3, 30, 8'b010, "R8 disabled");
    clear_all();
  endtask

  task automatic t_back_to_back();
    run_stream(5, 40, 8'b01110, 1'b1, "R4 back-to-back");
    check_sts(1'b1, 1'b1, "R4");
    drain(5, 40, 8'b01110, "R9 back-to-back");
    clear_all();
  endtask

  task automatic t_not_phase();
    per_en = 1'b1;
    @(negedge clk);
    rd_phase = 1'b1; irdy_n = 1'b0; trdy_n = 1'b1; ad = word_of(50); cbe_n = cbe_of(50);
    @(negedge clk);
    par = ~good_par(50);
    irdy_n = 1'b1; trdy_n = 1'b0; ad = word_of(51); cbe_n = cbe_of(51);
    @(negedge clk);
    par = ~good_par(51);
    rd_phase = 1'b0; irdy_n = 1'b0; trdy_n = 1'b0; ad = word_of(52); cbe_n = cbe_of(52);
    @(negedge clk);
    par = ~good_par(52);
    idle_bus();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(perr_n == 1'b1, "R2", "perr_n on non-phase", 32'(perr_n), 32'd1);
    end
    check_sts(1'b0, 1'b0, "R2");
    check(fwd_valid == 1'b0, "R2", "nothing forwarded", 32'(fwd_valid), 32'd0);
    par = 1'b0;
  endtask

  task automatic t_clear_collision();
    per_en = 1'b1;
    @(negedge clk);
    rd_phase = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0; ad = word_of(60); cbe_n = cbe_of(60);
    @(negedge clk);
    idle_bus(); par = ~good_par(60);
    @(negedge clk);
    par = 1'b0; clr_dpe = 1'b1; clr_dpd = 1'b1;
    @(negedge clk);
    clr_dpe = 1'b0; clr_dpd = 1'b0;
    check(perr_n == 1'b0, "R3 collision", "perr_n", 32'(perr_n), 32'd0);
    check_sts(1'b1, 1'b1, "R7 error beats clear");
    drain(1, 60, 8'b1, "R8 collision");
    clear_all();
  endtask

  task automatic t_flush();
    run_stream(3, 70, 8'b001, 1'b1, "R3 pre-flush");
    @(negedge clk); fwd_flush = 1'b1;
    @(negedge clk); fwd_flush = 1'b0;
    check(fwd_valid == 1'b0, "R10", "fwd_valid after flush", 32'(fwd_valid), 32'd0);
    run_stream(1, 80, 8'b0, 1'b1, "R10 after flush");
    drain(1, 80, 8'b0, "R10 no stale poison");
    clear_all();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_clean();
    t_single_err();
    t_err_disabled();
    t_back_to_back();
    t_not_phase();
    t_clear_collision();
    t_flush();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule